// File: doc/BRIEF.md
# Signed Array Multiplier

This block multiplies two N-bit two's-complement operands and returns their full 2N-bit two's-complement product. The hardware is an unsigned-style array. Each partial-product bit is one AND gate. The rows are summed by half and full adders. The array has no sign-extension columns. Every partial-product term that pairs one operand's sign bit with a non-sign bit of the other operand is inverted. The term formed from the two sign bits is used as it is. Two constant ones, at column N and at column 2N-1, are folded into the adder chain, and they cancel the sign weight. Any carry out of bit 2N-1 is dropped.

By default the block is purely combinational: the product follows the operands within the same cycle, and the clock and reset are used only by the embedded checks. The parameter `STAGE_AT` can place one register stage after the first `STAGE_AT` adder rows. This shortens the longest path at the cost of one cycle of latency. The stage holds the running sum and the operand bits that the later rows still need.

Top module: `smul_array`

## Requirements
- R1: With STAGE_AT = 0, p equals the signed product of a and b as a 2N-bit two's-complement value for every operand pair, within the same cycle and with no clock edge needed.
- R2: The most negative operand squared gives +2^(2N-2) (N = 4: a = 4'h8, b = 4'h8 gives p = 8'h40).
- R3: The most negative operand times the largest positive operand gives -2^(2N-2) + 2^(N-1) in either operand order (N = 4: 4'h8 times 4'h7 gives p = 8'hC8).
- R4: When either operand is zero, all bits of p are zero.
- R5: When both operands are nonzero, p[2N-1] equals the XOR of a[N-1] and b[N-1].
- R6: Multiplying by -1 (all ones) gives the negation of the other operand, sign-extended. This includes the most negative operand, which gives +2^(N-1) (N = 4: 4'h8 times 4'hF gives p = 8'h08).
- R7: With STAGE_AT = k, for k from 1 to N-1, p shows the exact signed product of the operands sampled at the previous rising clock edge.
- R8: With STAGE_AT > 0, a rising edge with rst_n low loads the stage with the state of a 0 times 0 product. From then until the next edge with rst_n high, p reads zero, whatever operands are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional row register stage and for the checks |
| rst_n | input | 1 | Synchronous active-low reset for the row register stage |
| a | input | N | Multiplicand, two's complement |
| b | input | N | Multiplier, two's complement |
| p | output | 2N | Product, two's complement |

## Verification
The embedded properties check, on every clock edge, that p matches a signed reference product, that a zero operand yields zero, and that the product sign follows the operand signs. In the staged variant they compare p against the operands of the previous edge, and they check that p is zero right after a reset edge. The bench alone shows the specific corner values: the most negative operand squared, the most negative operand times the largest positive one, and multiplication by -1. It also sweeps all 256 operand pairs at N = 4, and it shows that operands applied during reset do not reach the output of the staged N = 8 instance.

// File: rtl/smul_pkg.sv
// Package: constants shared by the signed array multiplier.
// Assumes 2 <= N <= 32 so that every constant fits in 64 bits.
package smul_pkg;

    // Correction ones injected at column n and column 2n-1.
    function automatic logic [63:0] corr_init(input int n);
        return (64'd1 << n) | (64'd1 << (2 * n - 1));
    endfunction

    // Running-sum value after k rows when both operands are zero:
    // each non-last row contributes its inverted sign-column term.
    function automatic logic [63:0] zero_prefix(input int n, input int k);
        logic [63:0] r;
        r = corr_init(n);
        for (int j = 0; j < k; j++) begin
            r = r + (64'd1 << (n - 1 + j));
        end
        return r;
    endfunction

endpackage

// File: rtl/smul_fa.sv
// Full adder cell: one bit of an adder row with carry in and carry out.
// Assumes nothing beyond single-bit inputs.
module smul_fa (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    // Sum and majority carry.
    always_comb begin
        s  = x ^ y ^ ci;
        co = (x & y) | (ci & (x ^ y));
    end
endmodule

// File: rtl/smul_ha.sv
// Half adder cell: used where an adder row has no partial-product bit.
// Assumes nothing beyond single-bit inputs.
module smul_ha (
    input  logic x,
    input  logic ci,
    output logic s,
    output logic co
);
    // Sum and carry of two bits.
    always_comb begin
        s  = x ^ ci;
        co = x & ci;
    end
endmodule

// File: rtl/smul_pp_row.sv
// Partial-product row J: the AND of every multiplicand bit with multiplier bit J.
// Terms that pair exactly one sign bit with a non-sign bit are inverted;
// the sign-by-sign term is kept as is. Assumes 0 <= J < N.
module smul_pp_row #(
    parameter int N = 4,
    parameter int J = 0
) (
    input  logic [N-1:0] mcand,
    input  logic         mbit,
    output logic [N-1:0] row
);
    localparam bit LAST_ROW = (J == N - 1);

    for (genvar i = 0; i < N; i++) begin : g_term
        localparam bit FLIP = LAST_ROW ? (i != N - 1) : (i == N - 1);
        if (FLIP) begin : g_inv
            // Sign-weighted term, complemented.
            assign row[i] = ~(mcand[i] & mbit);
        end else begin : g_plain
            // Ordinary term.
            assign row[i] = mcand[i] & mbit;
        end
    end
endmodule

// File: rtl/smul_row_add.sv
// One adder row: adds an N-bit partial-product row, shifted left by J,
// into a W-bit running sum. Bits below J pass through; columns covered
// by the row use full adders, the columns above use half adders, and
// the top column keeps only its sum, so the carry out of bit W-1 is lost.
// Assumes J + N < W.
module smul_row_add #(
    parameter int N = 4,
    parameter int W = 8,
    parameter int J = 0
) (
    input  logic [W-1:0] acc_in,
    input  logic [N-1:0] row,
    output logic [W-1:0] acc_out
);
    logic [W-1:J] carry;

    assign carry[J] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_col
        if (i < J) begin : g_pass
            // Column below this row: unchanged.
            assign acc_out[i] = acc_in[i];
        end else if (i == W - 1) begin : g_top
            // Top column: the carry out is discarded.
            assign acc_out[i] = acc_in[i] ^ carry[i];
        end else if (i - J < N) begin : g_full
            smul_fa u_fa (
                .x  (acc_in[i]),
                .y  (row[i-J]),
                .ci (carry[i]),
                .s  (acc_out[i]),
                .co (carry[i+1])
            );
        end else begin : g_half
            smul_ha u_ha (
                .x  (acc_in[i]),
                .ci (carry[i]),
                .s  (acc_out[i]),
                .co (carry[i+1])
            );
        end
    end
endmodule

// File: rtl/smul_array.sv
// Signed N x N array multiplier with a 2N-bit two's-complement product.
// The rows are summed in sequence starting from the correction constant.
// STAGE_AT = 0 gives a combinational path; STAGE_AT = k (1..N-1) registers
// the running sum after k rows, together with the operand bits that the
// later rows need. Synchronous active-low reset. Assumes 2 <= N <= 32.
module smul_array
    import smul_pkg::*;
#(
    parameter int N        = 4,
    parameter int STAGE_AT = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic [2*N-1:0] p
);
    localparam int W  = 2 * N;
    localparam int K  = STAGE_AT;
    localparam int HB = N - K;
    localparam logic [63:0]  INIT64 = corr_init(N);
    localparam logic [63:0]  RST64  = zero_prefix(N, K);
    localparam logic [W-1:0] INIT   = INIT64[W-1:0];
    localparam logic [W-1:0] RST_ACC = RST64[W-1:0];

    logic [W-1:0]  acc_in  [N];
    logic [W-1:0]  acc_out [N];
    logic [W-1:0]  acc_mid;
    logic [N-1:0]  a_late;
    logic [HB-1:0] b_late;

    if (K == 0) begin : g_comb
        assign acc_mid = INIT;
        assign a_late  = a;
        assign b_late  = b;
    end else begin : g_stage
        // Row register stage: holds the running sum and the operands for the later rows.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_mid <= RST_ACC;
                a_late  <= '0;
                b_late  <= '0;
            end else begin
                acc_mid <= acc_out[K-1];
                a_late  <= a;
                b_late  <= b[N-1:K];
            end
        end
    end

    for (genvar j = 0; j < N; j++) begin : g_row
        logic [N-1:0] mcand;
        logic         mbit;
        logic [N-1:0] row_bits;

        if (j < K) begin : g_early
            assign mcand = a;
            assign mbit  = b[j];
        end else begin : g_late
            assign mcand = a_late;
            assign mbit  = b_late[j-K];
        end

        if (j == K) begin : g_from_mid
            assign acc_in[j] = acc_mid;
        end else if (j == 0) begin : g_from_init
            assign acc_in[j] = INIT;
        end else begin : g_from_prev
            assign acc_in[j] = acc_out[j-1];
        end

        smul_pp_row #(.N(N), .J(j)) u_pp (
            .mcand (mcand),
            .mbit  (mbit),
            .row   (row_bits)
        );

        smul_row_add #(.N(N), .W(W), .J(j)) u_add (
            .acc_in  (acc_in[j]),
            .row     (row_bits),
            .acc_out (acc_out[j])
        );
    end

    assign p = acc_out[N-1];

    // Reference product for the checks: sign-extended operands, low W bits.
    logic signed [W-1:0] a_ext;
    logic signed [W-1:0] b_ext;
    logic signed [W-1:0] ref_now;
    assign a_ext   = {{N{a[N-1]}}, a};
    assign b_ext   = {{N{b[N-1]}}, b};
    assign ref_now = a_ext * b_ext;

    if (K == 0) begin : g_chk_comb
        // R1
        product_chk: assert property (@(posedge clk) disable iff (!rst_n)
            p == ref_now);
        // R4
        zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (a == '0 || b == '0) |-> p == '0);
        // R5
        sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (a != '0 && b != '0) |-> p[W-1] == (a[N-1] ^ b[N-1]));
    end else begin : g_chk_stage
        logic primed;
        // Marks that the stage has taken operands at least once since reset.
        always_ff @(posedge clk) begin
            if (!rst_n) primed <= 1'b0;
            else        primed <= 1'b1;
        end
        // R7
        product_chk: assert property (@(posedge clk) disable iff (!rst_n)
            primed |-> p == $past(ref_now));
        // R8
        reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!rst_n) |-> p == '0);
        // R4
        zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (primed && ($past(a) == '0 || $past(b) == '0)) |-> p == '0);
        // R5
        sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (primed && $past(a) != '0 && $past(b) != '0)
                |-> p[W-1] == ($past(a[N-1]) ^ $past(b[N-1])));
    end
endmodule

// File: tb/smul_array_test.sv
module smul_array_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n;
    logic [3:0]  a4, b4;
    logic [7:0]  p4;
    logic [7:0]  a8, b8;
    logic [15:0] p8;

    smul_array #(.N(4), .STAGE_AT(0)) uut (
        .clk(clk), .rst_n(rst_n), .a(a4), .b(b4), .p(p4)
    );
    smul_array #(.N(8), .STAGE_AT(4)) uut_pipe (
        .clk(clk), .rst_n(rst_n), .a(a8), .b(b8), .p(p8)
    );

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // Each entry: {a[3:0], b[3:0], expected p[7:0]}
    localparam logic [15:0] VEC [10] = '{
        16'h0000, 16'h8840, 16'h87C8, 16'h78C8, 16'h7731,
        16'hFF01, 16'h8F08, 16'h5000, 16'h3DF7, 16'h6312
    };

    function automatic string vec_tag(input int idx);
        case (idx)
            0, 7:    return "R4 zero operand";
            1:       return "R2 most negative squared";
            2, 3:    return "R3 most negative times max";
            5, 6:    return "R6 times minus one";
            8:       return "R5 mixed sign";
            default: return "R1 positive pair";
        endcase
    endfunction

    function automatic logic [7:0] ref4(input logic [3:0] x, input logic [3:0] y);
        int xi, yi;
        xi = int'($signed(x));
        yi = int'($signed(y));
        return 8'(xi * yi);
    endfunction

    function automatic logic [15:0] ref8(input logic [7:0] x, input logic [7:0] y);
        int xi, yi;
        xi = int'($signed(x));
        yi = int'($signed(y));
        return 16'(xi * yi);
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    initial begin
        logic [15:0] exp_prev;
        rst_n = 1'b0;
        a4 = '0; b4 = '0;
        a8 = 8'h5A; b8 = 8'hC3;
        repeat (2) begin
            @(negedge clk);
            check("R8 operands ignored in reset", p8, 16'h0000);
        end
        check("R4 reset state zero operands", {8'h00, p4}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        #1 check("R8 zero before first active edge", p8, 16'h0000);
        @(negedge clk);
        check("R7 first product after reset", p8, ref8(8'h5A, 8'hC3));

        for (int idx = 0; idx < 10; idx++) begin
            @(negedge clk);
            a4 = VEC[idx][15:12];
            b4 = VEC[idx][11:8];
            #1 check(vec_tag(idx), {8'h00, p4}, {8'h00, VEC[idx][7:0]});
        end

        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                @(negedge clk);
                a4 = x[3:0];
                b4 = y[3:0];
                #1 check("R1 exhaustive", {8'h00, p4}, {8'h00, ref4(x[3:0], y[3:0])});
                if (x != 0 && y != 0)
                    check("R5 sign bit", {15'h0, p4[7]}, {15'h0, x[3] ^ y[3]});
            end
        end

        @(negedge clk);
        a8 = 8'h80; b8 = 8'h80;
        exp_prev = ref8(a8, b8);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            check("R7 staged product", p8, exp_prev);
            if (i == 0) begin
                a8 = 8'h80; b8 = 8'h7F;
            end else if (i == 1) begin
                a8 = 8'hFF; b8 = 8'h80;
            end else begin
                a8 = 8'($urandom);
                b8 = 8'($urandom);
            end
            exp_prev = ref8(a8, b8);
        end
        @(negedge clk);
        check("R7 staged last product", p8, exp_prev);

        rst_n = 1'b0;
        a8 = 8'h77; b8 = 8'h99;
        @(negedge clk);
        check("R8 mid-run reset clears", p8, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 product after mid-run reset", p8, ref8(8'h77, 8'h99));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R1 got=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule